// File: doc/BRIEF.md
# Registered Integer ALU with Signed and Unsigned Compare

This block is the arithmetic and logic unit of a small load-store RISC core. It takes two data words, a shift amount and a four-bit operation select. It produces a data word and a flag that is set when that word is all zeros. The operations are wrapping add and subtract, bitwise AND, OR and NOR, zero-filling logical shifts by an immediate amount, set-less-than in signed and unsigned forms, and upper-half constant placement. Branch logic tests two registers for equality by selecting subtract and reading the zero flag.

Immediates reach the ALU already sign- or zero-extended, so a negative constant arrives as a full-width two's-complement word. A bitwise NOT is obtained as NOR against a zero operand. Subtract, signed compare and unsigned compare all share one adder. Both outputs are registered, so a result appears one clock after its operands are presented.

Top module: `word_alu`

## Requirements
- R1: With op_sel = 0 (add), res_q equals (opnd_a + opnd_b) mod 2^32, including when opnd_b is a sign-extended negative value. No exception or flag other than zero_q is raised.
- R2: With op_sel = 1 (subtract), res_q equals (opnd_a - opnd_b) mod 2^32.
- R3: op_sel = 2 gives the bitwise AND of the operands, and op_sel = 3 gives the bitwise OR.
- R4: op_sel = 4 gives the bitwise NOR of the operands. NOR with opnd_b = 0 returns ~opnd_a.
- R5: op_sel = 5 shifts opnd_a left by shamt, and op_sel = 6 shifts it right by shamt. In both cases the vacated bits are filled with zeros and opnd_b is ignored.
- R6: op_sel = 7 (signed less-than) returns 1 when opnd_a < opnd_b as two's-complement numbers and 0 otherwise. For example, 0xFFFFFFFF against 1 gives 1. Bits 31:1 of the result are zero.
- R7: op_sel = 8 (unsigned less-than) returns 1 when opnd_a < opnd_b as unsigned numbers and 0 otherwise. For example, 0xFFFFFFFF against 1 gives 0. Bits 31:1 of the result are zero.
- R8: op_sel = 9 (load upper) puts opnd_b[15:0] into result bits 31:16 and clears bits 15:0. opnd_a is ignored.
- R9: zero_q is 1 exactly when res_q is all zeros. Subtracting equal operands therefore sets it, and subtracting unequal operands clears it.
- R10: op_sel values 10 to 15 give a result of zero.
- R11: The result of the operands presented before a rising clock edge appears on res_q and zero_q after that edge. A synchronous active-high rst sets res_q to 0 and zero_q to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_sel | input | 4 | Operation select (encodings in R1 to R10) |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand or pre-extended immediate |
| shamt | input | 5 | Shift amount for the logical shifts |
| res_q | output | 32 | Registered result |
| zero_q | output | 1 | Registered all-zero flag of res_q |

## Verification
The assertions assume that inputs are stable across each rising edge and that every op_sel value has a defined meaning, including the six unused codes, which must give zero. They also assume that nothing about prior operations matters, because each result depends only on the operands of the previous cycle. The stimulus changes inputs only on falling edges. It drives every one of the 16 select codes, including the unused ones. It combines directed corner operands (all ones, sign-boundary values, equal pairs, shift amounts 0 and 31) with a pseudo-random sweep, so every encoding is exercised with both sign bits of each operand.

// File: rtl/word_alu_pkg.sv
package word_alu_pkg;
  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_AND  = 4'd2,
    OP_OR   = 4'd3,
    OP_NOR  = 4'd4,
    OP_SLL  = 4'd5,
    OP_SRL  = 4'd6,
    OP_SLT  = 4'd7,
    OP_SLTU = 4'd8,
    OP_LUI  = 4'd9
  } alu_op_e;
endpackage

// File: rtl/word_alu_addsub.sv
// Shared adder: add, subtract, and both less-than results derived from the difference.
module word_alu_addsub #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              sub,
  output logic [DATA_W-1:0] sum,
  output logic              lt_signed,
  output logic              lt_unsigned
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W:0]   wide;
  logic [DATA_W-1:0] b_eff;

  always_comb begin
    b_eff = b ^ {DATA_W{sub}};
    wide  = {1'b0, a} + {1'b0, b_eff} + (DATA_W+1)'(sub);
    sum   = wide[DATA_W-1:0];
    // with sub set, a missing carry out means a borrow: a < b unsigned
    lt_unsigned = ~wide[DATA_W];
    // differing signs decide directly; equal signs cannot overflow
    lt_signed = (a[MSB] ^ b[MSB]) ? a[MSB] : wide[MSB];
  end
endmodule

// File: rtl/word_alu_shift.sv
// Logarithmic zero-filling shifter, one stage per shift amount bit.
module word_alu_shift #(
  parameter int DATA_W  = 32,
  parameter int SHAMT_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0]  a,
  input  logic [SHAMT_W-1:0] shamt,
  output logic [DATA_W-1:0]  left,
  output logic [DATA_W-1:0]  right
);
  logic [DATA_W-1:0] lst [0:SHAMT_W];
  logic [DATA_W-1:0] rst_stage [0:SHAMT_W];

  assign lst[0]       = a;
  assign rst_stage[0] = a;

  for (genvar s = 0; s < SHAMT_W; s++) begin : g_stage
    localparam int DIST = 1 << s;
    assign lst[s+1]       = shamt[s] ? (lst[s] << DIST)       : lst[s];
    assign rst_stage[s+1] = shamt[s] ? (rst_stage[s] >> DIST) : rst_stage[s];
  end

  assign left  = lst[SHAMT_W];
  assign right = rst_stage[SHAMT_W];
endmodule

// File: rtl/word_alu_logic.sv
// Bitwise operations and upper-half constant placement.
module word_alu_logic #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = DATA_W / 2
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] and_w,
  output logic [DATA_W-1:0] or_w,
  output logic [DATA_W-1:0] nor_w,
  output logic [DATA_W-1:0] upper_w
);
  localparam int LOW_W = DATA_W - IMM_W;

  always_comb begin
    and_w   = a & b;
    or_w    = a | b;
    nor_w   = ~(a | b);
    upper_w = {b[IMM_W-1:0], {LOW_W{1'b0}}};
  end
endmodule

// File: rtl/word_alu.sv
module word_alu
  import word_alu_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int SHAMT_W = $clog2(DATA_W)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [OP_W-1:0]    op_sel,
  input  logic [DATA_W-1:0]  opnd_a,
  input  logic [DATA_W-1:0]  opnd_b,
  input  logic [SHAMT_W-1:0] shamt,
  output logic [DATA_W-1:0]  res_q,
  output logic               zero_q
);
  logic [DATA_W-1:0] sum_w, sll_w, srl_w, and_w, or_w, nor_w, up_w;
  logic              slt_w, sltu_w, do_sub;
  logic [DATA_W-1:0] res_d;
  alu_op_e           op;

  assign op     = alu_op_e'(op_sel);
  assign do_sub = (op != OP_ADD);

  word_alu_addsub #(.DATA_W(DATA_W)) u_addsub (
    .a(opnd_a), .b(opnd_b), .sub(do_sub),
    .sum(sum_w), .lt_signed(slt_w), .lt_unsigned(sltu_w)
  );

  word_alu_shift #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W)) u_shift (
    .a(opnd_a), .shamt(shamt), .left(sll_w), .right(srl_w)
  );

  word_alu_logic #(.DATA_W(DATA_W)) u_logic (
    .a(opnd_a), .b(opnd_b),
    .and_w(and_w), .or_w(or_w), .nor_w(nor_w), .upper_w(up_w)
  );

  always_comb begin
    unique case (op)
      OP_ADD, OP_SUB: res_d = sum_w;
      OP_AND:         res_d = and_w;
      OP_OR:          res_d = or_w;
      OP_NOR:         res_d = nor_w;
      OP_SLL:         res_d = sll_w;
      OP_SRL:         res_d = srl_w;
      OP_SLT:         res_d = DATA_W'(slt_w);
      OP_SLTU:        res_d = DATA_W'(sltu_w);
      OP_LUI:         res_d = up_w;
      default:        res_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q  <= '0;
      zero_q <= 1'b1;
    end else begin
      res_q  <= res_d;
      zero_q <= (res_d == '0);
    end
  end
endmodule

// File: rtl/word_alu_chk.sv
module word_alu_chk
  import word_alu_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int SHAMT_W = $clog2(DATA_W)
) (
  input logic               clk,
  input logic               rst,
  input logic [OP_W-1:0]    op_sel,
  input logic [DATA_W-1:0]  opnd_a,
  input logic [DATA_W-1:0]  opnd_b,
  input logic [SHAMT_W-1:0] shamt,
  input logic [DATA_W-1:0]  res_q,
  input logic               zero_q
);
  localparam int HALF = DATA_W / 2;

  p_add_wrap_r1: assert property (@(posedge clk) disable iff (rst)
    (op_sel == OP_ADD) |=> (res_q == $past(opnd_a + opnd_b)));

  p_sub_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    (op_sel == OP_SUB) |=> (res_q == $past(opnd_a - opnd_b)));

  p_slt_narrow_r6: assert property (@(posedge clk) disable iff (rst)
    (op_sel == OP_SLT) |=> (res_q[DATA_W-1:1] == '0));

  p_sltu_narrow_r7: assert property (@(posedge clk) disable iff (rst)
    (op_sel == OP_SLTU) |=> (res_q[DATA_W-1:1] == '0));

  p_lui_place_r8: assert property (@(posedge clk) disable iff (rst)
    (op_sel == OP_LUI) |=> (res_q == {$past(opnd_b[HALF-1:0]), {HALF{1'b0}}}));

  p_zero_flag_r9: assert property (@(posedge clk) disable iff (rst)
    !$isunknown(op_sel) |=> (zero_q == (res_q == '0)));

  p_unknown_op_r10: assert property (@(posedge clk) disable iff (rst)
    (op_sel > 4'd9) |=> (res_q == '0));

  p_reset_state_r11: assert property (@(posedge clk)
    rst |=> (res_q == '0 && zero_q));
endmodule

bind word_alu word_alu_chk #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W)) u_chk (
  .clk(clk), .rst(rst), .op_sel(op_sel), .opnd_a(opnd_a), .opnd_b(opnd_b),
  .shamt(shamt), .res_q(res_q), .zero_q(zero_q)
);

// File: tb/word_alu_tb_top.sv
module word_alu_tb_top;
  localparam int  W     = 32;
  localparam time T_CLK = 8ns;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [3:0]   op_sel = '0;
  logic [W-1:0] opnd_a = '0, opnd_b = '0;
  logic [4:0]   shamt = '0;
  logic [W-1:0] res_q;
  logic         zero_q;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;
  logic [31:0] seed = 32'h1234_5678;

  always #(T_CLK/2) clk = ~clk;

  word_alu dut_i (
    .clk(clk), .rst(rst), .op_sel(op_sel), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .shamt(shamt), .res_q(res_q), .zero_q(zero_q)
  );

  function automatic logic [31:0] model(input logic [3:0] op, input logic [31:0] a,
                                        input logic [31:0] b, input logic [4:0] sh);
    longint sa, sb;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    case (op)
      4'd0: return 32'((longint'(a) + longint'(b)) % 64'h1_0000_0000);
      4'd1: return 32'((longint'(a) - longint'(b) + 64'h1_0000_0000) % 64'h1_0000_0000);
      4'd2: return a & b;
      4'd3: return a | b;
      4'd4: return ~(a | b);
      4'd5: return a << sh;
      4'd6: return a >> sh;
      4'd7: return (sa < sb) ? 32'd1 : 32'd0;
      4'd8: return (longint'(a) < longint'(b)) ? 32'd1 : 32'd0;
      4'd9: return {b[15:0], 16'h0000};
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag_of(input logic [3:0] op);
    case (op)
      4'd0: return "R1";
      4'd1: return "R2";
      4'd2, 4'd3: return "R3";
      4'd4: return "R4";
      4'd5, 4'd6: return "R5";
      4'd7: return "R6";
      4'd8: return "R7";
      4'd9: return "R8";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // drive on falling edge, result registered at next rising edge, sample on next falling edge
  task automatic run(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                     input logic [4:0] sh);
    logic [31:0] exp;
    op_sel = op; opnd_a = a; opnd_b = b; shamt = sh;
    exp = model(op, a, b, sh);
    @(negedge clk);
    check(tag_of(op), res_q, exp);
    check("R9", {31'd0, zero_q}, {31'd0, exp == 32'd0});
  endtask

  function automatic logic [31:0] next_rand(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11", res_q, 32'd0);
    check("R11", {31'd0, zero_q}, 32'd1);
    rst = 1'b0;
    @(negedge clk);

    run(4'd0, 32'd10, 32'hFFFF_FFFF, 5'd3);   // R1 negative immediate: 10 + -1 = 9
    run(4'd0, 32'hFFFF_FFFF, 32'd1, 5'd0);    // R1 wrap to zero
    run(4'd1, 32'd0, 32'd1, 5'd0);            // R2 wrap to all ones
    run(4'd1, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 5'd0); // R9 equal operands
    run(4'd1, 32'hDEAD_BEEF, 32'hDEAD_BEEE, 5'd0); // R9 unequal
    run(4'd2, 32'h0000_0DC0, 32'h0000_3C00, 5'd0); // R3
    run(4'd3, 32'h0000_0DC0, 32'h0000_3C00, 5'd0); // R3
    run(4'd4, 32'h0000_0DC0, 32'd0, 5'd0);    // R4 NOT via NOR
    run(4'd5, 32'h8000_0001, 32'hFFFF_FFFF, 5'd31); // R5
    run(4'd5, 32'h1234_5678, 32'd0, 5'd0);    // R5
    run(4'd6, 32'h8000_0000, 32'hFFFF_FFFF, 5'd31); // R5 zero fill
    run(4'd7, 32'hFFFF_FFFF, 32'd1, 5'd0);    // R6 -1 < 1
    run(4'd8, 32'hFFFF_FFFF, 32'd1, 5'd0);    // R7 not less
    run(4'd7, 32'h7FFF_FFFF, 32'h8000_0000, 5'd0); // R6 boundary
    run(4'd8, 32'h7FFF_FFFF, 32'h8000_0000, 5'd0); // R7 boundary
    run(4'd8, 32'd5, 32'd5, 5'd0);            // R7 equal
    run(4'd9, 32'hFFFF_FFFF, 32'hABCD_007D, 5'd0); // R8
    for (int op = 10; op < 16; op++)
      run(4'(op), 32'hFFFF_FFFF, 32'h1234_5678, 5'd7); // R10

    for (int i = 0; i < 600; i++) begin
      logic [31:0] ra, rb, rs;
      seed = next_rand(seed); ra = seed;
      seed = next_rand(seed); rb = (i % 7 == 0) ? ra : seed;
      seed = next_rand(seed); rs = seed;
      run(rs[3:0], ra, rb, rs[8:4]);
    end

    // R11 synchronous reset mid-run
    op_sel = 4'd3; opnd_a = 32'hFFFF_FFFF; opnd_b = 32'd0; rst = 1'b1;
    @(negedge clk);
    check("R11", res_q, 32'd0);
    check("R11", {31'd0, zero_q}, 32'd1);
    rst = 1'b0;
    @(negedge clk);
    check("R11", res_q, 32'hFFFF_FFFF);

    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule